// File: doc/BRIEF.md
# Byte-Lane Read Timing Calibration Sequencer

This block calibrates the read-side timing of a multi-lane DDR data path. A single start pulse launches a run that first hands control to an external write leveling engine through a request/acknowledge pair. Once that engine acknowledges, two delay sweeps follow. The first sweep trains the read strobe gate. The second trains the data capture point inside the valid data eye. During each sweep every lane steps through all delay taps together. For each lane the sequencer records the first and the last tap that a data compare unit reports as passing, and it takes the midpoint as that lane's trained setting.

The tap under trial goes out on a trial bus, and the surrounding delay-line logic applies it. After each tap change the sequencer waits a fixed settle time. It then asks the compare unit for a verdict through a valid/ready handshake. The sequencer raises ready and holds it until valid arrives, so the compare unit applies back-pressure simply by delaying valid. One verdict, one pass bit per lane, is consumed on each cycle where both valid and ready are high. The committed gate and eye delay outputs change only at the end of a run. A lane whose window is missing or too narrow raises its error flag and keeps its previous settings, while the other lanes still finish and update.

Top module: `rdlvl_seq`

## Requirements
- R1: A run goes through its phases in a fixed order. `wl_req_o` rises in the cycle after `start_i` is taken while idle. No compare request (`cmp_ready_o`) is raised while `wl_req_o` is high. The gate sweep (`trial_stage_o`=0) fully precedes the eye sweep (`trial_stage_o`=1).
- R2: After the trial tap changes within a sweep, `cmp_ready_o` stays low for exactly SETTLE cycles (default 8) before it rises.
- R3: Each sweep presents taps 0,1,...,2^TAP_W-1 (0..63 by default) in ascending order. Exactly one verdict is consumed per tap, so a full run consumes 128 verdicts.
- R4: A verdict is consumed only on a cycle where `cmp_valid_i` and `cmp_ready_o` are both high. Once raised, `cmp_ready_o` stays high until a verdict is taken.
- R5: A lane's trained gate delay is (lo+hi)>>1, rounded down. Here lo is the first passing tap and hi is the last passing tap of the gate sweep. Bit lane L of `cmp_pass_i` is lane L's verdict.
- R6: During the eye sweep, each lane's field of `trial_gate_o` (bits L*TAP_W upward) carries that lane's freshly trained gate midpoint. During the gate sweep the field carries the tap under trial.
- R7: A lane's trained eye delay is (lo+hi)>>1 over the passing taps of the eye sweep.
- R8: A lane is in error when either sweep has no passing tap or has a window (hi-lo+1) narrower than MIN_WIN (default 2). `lane_err_o` bit L flags lane L. `fail_o` is the OR of those bits. Both are valid from the `done_o` pulse until the next start.
- R9: At the end of a run, lanes without error commit their new gate and eye delays. Lanes in error keep their previous committed values.
- R10: `start_i` is ignored while `busy_o` is high. It causes no further write leveling request and no extra `done_o` pulse.
- R11: `gate_dly_o` and `eye_dly_o` hold their values during a run. They change only in the cycle where `done_o` pulses for one cycle.
- R12: After reset, the block is idle with all outputs low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a calibration run (taken only while idle) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | At least one lane failed in the last run |
| lane_err_o | output | LANES | Per-lane error flags of the last run |
| wl_req_o | output | 1 | Write leveling request, held until acknowledged |
| wl_ack_i | input | 1 | Write leveling complete |
| trial_stage_o | output | 1 | Sweep in progress: 0 gate, 1 eye |
| trial_tap_o | output | TAP_W | Tap under trial for the current sweep |
| trial_gate_o | output | LANES*TAP_W | Per-lane gate delay to apply while sweeping |
| cmp_ready_o | output | 1 | Sequencer ready to take a verdict |
| cmp_valid_i | input | 1 | Compare unit verdict valid |
| cmp_pass_i | input | LANES | Per-lane pass bits of the verdict |
| gate_dly_o | output | LANES*TAP_W | Committed per-lane gate delays |
| eye_dly_o | output | LANES*TAP_W | Committed per-lane eye capture delays |

## Verification
`wl_req_o` is due one cycle after the start is taken. It drops in the cycle after the acknowledge. Within a sweep, `cmp_ready_o` is due exactly SETTLE cycles after the accepted verdict that stepped the tap. The committed delays and error flags appear together with `done_o`, one cycle after the 64th verdict of the eye sweep plus one cycle for the midpoint. The bench samples every output on the falling edge. It recognises an accepted verdict from the ready/valid values held across the preceding rising edge, and it compares the result of each run against a queued expectation at the `done_o` pulse. Because the compare unit answers with a lag that varies from tap to tap, the hold-ready and settle-gap checks see both immediate and delayed answers.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLVL,
    ST_SETTLE,
    ST_SAMPLE,
    ST_MID
  } seq_st_e;

  typedef enum logic {
    STG_GATE = 1'b0,
    STG_EYE  = 1'b1
  } sweep_stg_e;

endpackage

// File: rtl/rdlvl_settle.sv
module rdlvl_settle #(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // expiry lasts a single cycle because the sequencer leaves the settle phase
  assert_expire_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

endmodule

// File: rtl/rdlvl_win.sv
module rdlvl_win #(
  parameter int TAP_W   = 6,
  parameter int MIN_WIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] mid,
  output logic             bad
);
  localparam logic [TAP_W:0] MINW = (TAP_W+1)'(MIN_WIN);

  logic             found;
  logic [TAP_W-1:0] lo, hi;
  logic [TAP_W:0]   sum, width;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      found <= 1'b0;
      lo    <= '0;
      hi    <= '0;
    end else if (smp && pass) begin
      if (!found) begin
        found <= 1'b1;
        lo    <= tap;
      end
      hi <= tap;
    end
  end

  assign sum   = {1'b0, lo} + {1'b0, hi};
  assign mid   = sum[TAP_W:1];
  assign width = {1'b0, hi} - {1'b0, lo} + 1'b1;
  assign bad   = !found || (width < MINW);

  assert_win_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (lo <= hi));

  assert_first_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> (lo == hi));

endmodule

// File: rtl/rdlvl_seq.sv
module rdlvl_seq
  import rdlvl_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int TAP_W   = 6,
  parameter int SETTLE  = 8,
  parameter int MIN_WIN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fail_o,
  output logic [LANES-1:0]       lane_err_o,
  output logic                   wl_req_o,
  input  logic                   wl_ack_i,
  output logic                   trial_stage_o,
  output logic [TAP_W-1:0]       trial_tap_o,
  output logic [LANES*TAP_W-1:0] trial_gate_o,
  output logic                   cmp_ready_o,
  input  logic                   cmp_valid_i,
  input  logic [LANES-1:0]       cmp_pass_i,
  output logic [LANES*TAP_W-1:0] gate_dly_o,
  output logic [LANES*TAP_W-1:0] eye_dly_o
);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  seq_st_e    state;
  sweep_stg_e stage;
  logic [TAP_W-1:0] tap;

  logic [LANES-1:0][TAP_W-1:0] gmid_q, gate_q, eye_q, w_mid, tg;
  logic [LANES-1:0] gbad_q, w_bad, err_q, run_err;
  logic fail_q, done_q, settle_exp, win_clr, win_smp;

  assign win_clr = (state == ST_WLVL) || (state == ST_MID);
  assign win_smp = (state == ST_SAMPLE) && cmp_valid_i;

  rdlvl_settle #(.SETTLE(SETTLE)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_SETTLE),
    .expired (settle_exp)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rdlvl_win #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (win_clr),
      .smp   (win_smp),
      .pass  (cmp_pass_i[l]),
      .tap   (tap),
      .mid   (w_mid[l]),
      .bad   (w_bad[l])
    );
    assign run_err[l] = gbad_q[l] | w_bad[l];
    assign tg[l]      = (stage == STG_EYE) ? gmid_q[l] : tap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      stage  <= STG_GATE;
      tap    <= '0;
      gmid_q <= '0;
      gbad_q <= '0;
      gate_q <= '0;
      eye_q  <= '0;
      err_q  <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state  <= ST_WLVL;
            err_q  <= '0;
            fail_q <= 1'b0;
          end
        end
        ST_WLVL: begin
          if (wl_ack_i) begin
            state <= ST_SETTLE;
            stage <= STG_GATE;
            tap   <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_exp) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (cmp_valid_i) begin
            if (tap == TAP_LAST) begin
              state <= ST_MID;
            end else begin
              tap   <= tap + 1'b1;
              state <= ST_SETTLE;
            end
          end
        end
        ST_MID: begin
          if (stage == STG_GATE) begin
            gmid_q <= w_mid;
            gbad_q <= w_bad;
            stage  <= STG_EYE;
            tap    <= '0;
            state  <= ST_SETTLE;
          end else begin
            for (int l = 0; l < LANES; l++) begin
              if (!run_err[l]) begin
                gate_q[l] <= gmid_q[l];
                eye_q[l]  <= w_mid[l];
              end
            end
            err_q  <= run_err;
            fail_q <= |run_err;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state != ST_IDLE);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign lane_err_o    = err_q;
  assign wl_req_o      = (state == ST_WLVL);
  assign cmp_ready_o   = (state == ST_SAMPLE);
  assign trial_stage_o = stage;
  assign trial_tap_o   = tap;
  assign trial_gate_o  = tg;
  assign gate_dly_o    = gate_q;
  assign eye_dly_o     = eye_q;

  assert_wl_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_req_o) |-> $past(state == ST_IDLE));

  assert_ready_after_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready_o) |-> $past(settle_exp));

  assert_hold_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready_o && !cmp_valid_i) |=> cmp_ready_o);

  assert_tap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready_o && cmp_valid_i && (trial_tap_o != TAP_LAST)) |=>
      (trial_tap_o == $past(trial_tap_o) + 1'b1));

  assert_no_cmp_in_wl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wl_req_o |-> !cmp_ready_o);

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(gate_dly_o) && $stable(eye_dly_o)));

  assert_fail_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fail_o == (lane_err_o != '0)));

endmodule

// File: tb/rdlvl_seq_tb.sv
module rdlvl_seq_tb;
  localparam int L = 4;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic wl_ack_i = 1'b0;
  logic cmp_valid_i = 1'b0;
  logic [L-1:0] cmp_pass_i = '0;
  logic busy_o, done_o, fail_o, wl_req_o, trial_stage_o, cmp_ready_o;
  logic [L-1:0] lane_err_o;
  logic [W-1:0] trial_tap_o;
  logic [L*W-1:0] trial_gate_o, gate_dly_o, eye_dly_o;

  always #4 clk = ~clk;

  rdlvl_seq #(.LANES(L), .TAP_W(W), .SETTLE(8), .MIN_WIN(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .lane_err_o(lane_err_o),
    .wl_req_o(wl_req_o), .wl_ack_i(wl_ack_i), .trial_stage_o(trial_stage_o),
    .trial_tap_o(trial_tap_o), .trial_gate_o(trial_gate_o),
    .cmp_ready_o(cmp_ready_o), .cmp_valid_i(cmp_valid_i),
    .cmp_pass_i(cmp_pass_i), .gate_dly_o(gate_dly_o), .eye_dly_o(eye_dly_o)
  );

  typedef struct {
    logic [L*W-1:0] g;
    logic [L*W-1:0] e;
    logic [L-1:0]   err;
  } exp_t;
  exp_t exp_q[$];

  int tests = 0, fails = 0;
  int glo[L], ghi[L], elo[L], ehi[L];
  int cur_gm[L];
  bit cur_gok[L];
  logic [L*W-1:0] prev_g = '0, prev_e = '0;
  int done_cnt = 0, acc_cnt = 0, wlreq_rises = 0;
  int exp_tap = 0, exp_stage = 0, low_cnt = 0;
  logic p_ready = 1'b0, p_valid = 1'b0, p_stage = 1'b0, p_wl = 1'b0;
  logic [W-1:0] p_tap = '0;
  int lag_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // responder and monitor share one falling-edge process
  always @(negedge clk) begin
    if (rst_n) begin
      // R1 no compare request during write leveling
      if (wl_req_o) chk(!cmp_ready_o, "R1", "ready during wl", cmp_ready_o, 0);
      if (wl_req_o && !p_wl) wlreq_rises++;
      // R4 ready held until a verdict is taken
      if (p_ready && !p_valid) chk(cmp_ready_o, "R4", "ready dropped", cmp_ready_o, 1);
      // accepted verdict across the last rising edge: R3 tap order, R1 stage order
      if (p_ready && p_valid) begin
        chk(p_tap == exp_tap[W-1:0], "R3", "swept tap", p_tap, exp_tap);
        chk(p_stage == exp_stage[0], "R1", "sweep stage", p_stage, exp_stage);
        acc_cnt++;
        if (exp_tap == 63) begin exp_tap = 0; exp_stage ^= 1; end
        else exp_tap++;
      end
      // R2 settle gap between taps
      if (cmp_ready_o && !p_ready) begin
        if (trial_tap_o != 0) chk(low_cnt == 8, "R2", "settle gap", low_cnt, 8);
        // R6 trained gate presented during the eye sweep
        if (trial_stage_o)
          for (int l = 0; l < L; l++)
            if (cur_gok[l])
              chk(trial_gate_o[l*W +: W] == cur_gm[l][W-1:0], "R6", "trial gate",
                  trial_gate_o[l*W +: W], cur_gm[l]);
        low_cnt = 0;
      end else if (!cmp_ready_o && busy_o) low_cnt++;
      if (done_o) begin
        exp_t x;
        done_cnt++;
        chk(acc_cnt == 128, "R3", "verdicts per run", acc_cnt, 128);
        if (exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          x = exp_q.pop_front();
          chk(gate_dly_o == x.g, "R5", "gate delays", gate_dly_o, x.g);
          chk(eye_dly_o == x.e, "R7", "eye delays", eye_dly_o, x.e);
          chk(lane_err_o == x.err, "R8", "lane errors", lane_err_o, x.err);
          chk(fail_o == (x.err != 0), "R8", "fail flag", fail_o, x.err != 0);
        end
      end
      // compare unit: answer with a tap-dependent lag
      if (cmp_ready_o && !cmp_valid_i) begin
        if (lag_cnt >= int'(trial_tap_o) % 3) begin
          cmp_valid_i = 1'b1;
          lag_cnt = 0;
          for (int l = 0; l < L; l++)
            cmp_pass_i[l] = trial_stage_o ?
              (int'(trial_tap_o) >= elo[l] && int'(trial_tap_o) <= ehi[l]) :
              (int'(trial_tap_o) >= glo[l] && int'(trial_tap_o) <= ghi[l]);
        end else lag_cnt++;
      end else if (!cmp_ready_o) begin
        cmp_valid_i = 1'b0;
        lag_cnt = 0;
      end
    end
    p_ready = cmp_ready_o; p_valid = cmp_valid_i; p_tap = trial_tap_o;
    p_stage = trial_stage_o; p_wl = wl_req_o;
  end

  function automatic bit win_bad(input int lo, input int hi);
    return (lo > hi) || (hi - lo + 1 < 2);
  endfunction

  task automatic run_case(input int ack_lag, input bit spam);
    exp_t x;
    logic [L*W-1:0] old_g, old_e;
    int d0, w0;
    old_g = prev_g; old_e = prev_e;
    x.g = prev_g; x.e = prev_e; x.err = '0;
    for (int l = 0; l < L; l++) begin
      bit gb, eb;
      gb = win_bad(glo[l], ghi[l]);
      eb = win_bad(elo[l], ehi[l]);
      cur_gok[l] = (glo[l] <= ghi[l]);
      cur_gm[l]  = (glo[l] + ghi[l]) >> 1;
      x.err[l] = gb | eb;
      if (!(gb | eb)) begin
        x.g[l*W +: W] = W'((glo[l] + ghi[l]) >> 1);
        x.e[l*W +: W] = W'((elo[l] + ehi[l]) >> 1);
      end
    end
    prev_g = x.g; prev_e = x.e;
    exp_q.push_back(x);
    exp_tap = 0; exp_stage = 0; acc_cnt = 0;
    d0 = done_cnt; w0 = wlreq_rises;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(wl_req_o && busy_o, "R1", "wl request after start", {wl_req_o, busy_o}, 3);
    repeat (ack_lag) @(negedge clk);
    wl_ack_i = 1'b1;
    @(negedge clk) wl_ack_i = 1'b0;
    chk(!wl_req_o, "R1", "wl request cleared", wl_req_o, 0);
    if (spam) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    repeat (300) @(negedge clk);
    chk(gate_dly_o == old_g, "R11", "gate held mid-run", gate_dly_o, old_g);
    chk(eye_dly_o == old_e, "R11", "eye held mid-run", eye_dly_o, old_e);
    if (spam) begin
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", "done pulses per run", done_cnt - d0, 1);
    chk(wlreq_rises == w0 + 1, "R10", "wl requests per run", wlreq_rises - w0, 1);
    chk(!busy_o, "R10", "idle after run", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy_o && !done_o && !fail_o && !wl_req_o && !cmp_ready_o, "R12",
        "idle controls", {busy_o, done_o, fail_o, wl_req_o, cmp_ready_o}, 0);
    chk(gate_dly_o == 0 && eye_dly_o == 0 && lane_err_o == 0, "R12", "zero delays",
        gate_dly_o | eye_dly_o, 0);

    // all lanes good, windows touching both ends of the range (R5, R7)
    glo = '{10, 0, 50, 30}; ghi = '{20, 5, 63, 31};
    elo = '{5, 20, 0, 33};  ehi = '{40, 21, 63, 47};
    run_case(4, 1'b0);

    // R8, R9: lane0 no gate pass, lane1 gate width 1, lane3 no eye pass
    glo = '{70, 12, 40, 8}; ghi = '{-1, 12, 45, 9};
    elo = '{3, 3, 1, 70};   ehi = '{9, 9, 2, -1};
    run_case(0, 1'b0);

    // R10: repeated starts while busy; all lanes good again
    glo = '{1, 60, 17, 2}; ghi = '{62, 63, 40, 3};
    elo = '{7, 0, 11, 25}; ehi = '{8, 3, 58, 26};
    run_case(2, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule